// File: doc/BRIEF.md
# Lockable Pad Attribute Register Bank

This block is a memory-mapped register bank that configures the electrical attributes of two groups of pads. One group holds dedicated pads and the other holds multiplexed pads. Each group has a parameterised count, and each pad has one 32-bit register. The block does not store the attribute values. When software writes an attribute register, the block passes the low ten bits of the write data to the hardware side. At the same time it raises a one-cycle qualifier pulse for that register. The hardware side keeps the value, and reads return whatever the hardware side reports. Bits that are not implemented can therefore read back differently from what was written (WARL).

A single enable bit guards every attribute write. It resets to 1, and software can clear it by writing 0. Writing 1 never sets it again, so the configuration stays frozen until the next reset. Each access is a single-cycle request with a 32-bit address and data. A registered response follows one cycle later and carries read data and an error flag.

The ten attribute bits, from bit 0 upwards, are:
- bit 0: I/O inversion
- bit 1: emulated open-drain enable
- bit 2: pull enable
- bit 3: pull direction (1 = up)
- bit 4: keeper enable
- bit 5: Schmitt trigger enable
- bit 6: fast slew
- bits 8:7: drive strength (00 weakest)
- bit 9: reserved

The bank itself gives these bits no meaning.

Top module: `pad_attr_bank`

## Requirements
- R1: After reset the enable bit reads 1, `rsp_valid_o` is 0 and no qualifier pulse is raised.
- R2: A request accepted on `req_i` at clock edge T gives `rsp_valid_o` = 1 after edge T+1, with `rdata_o` and `err_o` valid in that same cycle. Writes return `rdata_o` = 0.
- R3: Bit 0 of the enable register at byte offset 0x0 is cleared by a write with data bit 0 = 0. A write with bit 0 = 1 leaves it unchanged, so once it is 0 it stays 0 until reset.
- R4: While the enable bit is 0, writes to attribute registers raise no qualifier pulse.
- R5: An attribute write while the enable bit is 1 raises, in the response cycle, exactly the qualifier bit of that register for one cycle. In the same cycle `attr_wdata_o` equals write data bits 9:0.
- R6: Dedicated pad k is at byte offset 4+4k. Multiplexed pad k is at byte offset 4*(1+NumDed+k).
- R7: An attribute read returns the hardware-reported value on bits 9:0, with bits 31:10 zero.
- R8: A read of the enable register returns the enable bit on bit 0, with bits 31:1 zero.
- R9: An access to an offset beyond the last register, or to an offset that is not 4-byte aligned, responds with `err_o` = 1 and `rdata_o` = 0. It raises no qualifier pulse and does not change the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AddrW | Byte offset |
| wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid |
| rdata_o | output | 32 | Read data |
| err_o | output | 1 | Unmapped or misaligned access |
| ded_attr_i | input | NumDed*10 | Hardware-reported dedicated pad attributes |
| mux_attr_i | input | NumMux*10 | Hardware-reported multiplexed pad attributes |
| attr_wdata_o | output | 10 | Attribute value being written |
| ded_qe_o | output | NumDed | Dedicated pad write qualifier pulses |
| mux_qe_o | output | NumMux | Multiplexed pad write qualifier pulses |

## Verification
The hardest situation to reach is the lock after it has been cleared. Writes of 1 to the enable register must leave it at 0, and every attribute write must then be dropped silently. The bench reaches it in three steps. It first clears the bit with a write whose upper bits are set but whose bit 0 is 0. It then hammers the enable register with writes of 1. Finally it sweeps every attribute register and confirms that no qualifier pulse appears and that the readback keeps its pre-lock value. The hardware side is modelled with bit 9 unimplemented, so each readback is the written value with bit 9 cleared.

// File: rtl/pad_attr_pkg.sv
package pad_attr_pkg;
  localparam int unsigned AttrW = 10;
  localparam int unsigned DataW = 32;
endpackage

// File: rtl/pad_attr_decode.sv
module pad_attr_decode #(
  parameter int unsigned NumDed = 4,
  parameter int unsigned NumMux = 6,
  parameter int unsigned AddrW  = 8
) (
  input  logic [AddrW-1:0]  addr_i,
  output logic              sel_lock_o,
  output logic [NumDed-1:0] sel_ded_o,
  output logic [NumMux-1:0] sel_mux_o,
  output logic              err_o
);
  localparam int unsigned DedBase = 1;
  localparam int unsigned MuxBase = DedBase + NumDed;

  logic [AddrW-3:0] word;
  logic             aligned;

  assign word    = addr_i[AddrW-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  assign sel_lock_o = aligned && (word == '0);

  for (genvar k = 0; k < NumDed; k++) begin : g_ded
    assign sel_ded_o[k] = aligned && (int'(word) == int'(DedBase) + k);
  end

  for (genvar k = 0; k < NumMux; k++) begin : g_mux
    assign sel_mux_o[k] = aligned && (int'(word) == int'(MuxBase) + k);
  end

  assign err_o = !(sel_lock_o || (|sel_ded_o) || (|sel_mux_o));
endmodule

// File: rtl/pad_attr_lock.sv
module pad_attr_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic wen_o
);
  logic wen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    wen_q <= 1'b1;
    else if (clr_i) wen_q <= 1'b0;
  end

  assign wen_o = wen_q;

  // R3: no path back to 1 once cleared
  p_lock_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wen_q |=> !wen_q);
endmodule

// File: rtl/pad_attr_bank.sv
module pad_attr_bank
  import pad_attr_pkg::*;
#(
  parameter int unsigned NumDed = 4,
  parameter int unsigned NumMux = 6,
  parameter int unsigned AddrW  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [AddrW-1:0]        addr_i,
  input  logic [DataW-1:0]        wdata_i,
  output logic                    rsp_valid_o,
  output logic [DataW-1:0]        rdata_o,
  output logic                    err_o,
  input  logic [NumDed*AttrW-1:0] ded_attr_i,
  input  logic [NumMux*AttrW-1:0] mux_attr_i,
  output logic [AttrW-1:0]        attr_wdata_o,
  output logic [NumDed-1:0]       ded_qe_o,
  output logic [NumMux-1:0]       mux_qe_o
);
  logic              sel_lock, dec_err, wen, wr;
  logic [NumDed-1:0] sel_ded;
  logic [NumMux-1:0] sel_mux;
  logic [DataW-1:0]  rd_c;

  pad_attr_decode #(.NumDed(NumDed), .NumMux(NumMux), .AddrW(AddrW)) u_dec (
    .addr_i     (addr_i),
    .sel_lock_o (sel_lock),
    .sel_ded_o  (sel_ded),
    .sel_mux_o  (sel_mux),
    .err_o      (dec_err)
  );

  assign wr = req_i && we_i;

  pad_attr_lock u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wr && sel_lock && !wdata_i[0]),
    .wen_o  (wen)
  );

  // read mux: selects are one-hot or empty
  always_comb begin
    rd_c = '0;
    if (sel_lock) rd_c[0] = wen;
    for (int k = 0; k < int'(NumDed); k++)
      if (sel_ded[k]) rd_c[AttrW-1:0] = rd_c[AttrW-1:0] | ded_attr_i[k*AttrW +: AttrW];
    for (int k = 0; k < int'(NumMux); k++)
      if (sel_mux[k]) rd_c[AttrW-1:0] = rd_c[AttrW-1:0] | mux_attr_i[k*AttrW +: AttrW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rdata_o      <= '0;
      err_o        <= 1'b0;
      attr_wdata_o <= '0;
      ded_qe_o     <= '0;
      mux_qe_o     <= '0;
    end else begin
      rsp_valid_o <= req_i;
      err_o       <= req_i && dec_err;
      rdata_o     <= (req_i && !we_i) ? rd_c : '0;
      ded_qe_o    <= (wr && wen) ? sel_ded : '0;
      mux_qe_o    <= (wr && wen) ? sel_mux : '0;
      if (wr) attr_wdata_o <= wdata_i[AttrW-1:0];
    end
  end

  p_rsp_follows_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);

  p_no_qe_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wen |=> (ded_qe_o == '0 && mux_qe_o == '0));

  p_qe_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ded_qe_o, mux_qe_o}));

  p_qe_needs_rsp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|{ded_qe_o, mux_qe_o}) |-> rsp_valid_o);

  p_err_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0 && ded_qe_o == '0 && mux_qe_o == '0));
endmodule

// File: tb/pad_attr_bank_test.sv
module pad_attr_bank_test;
  localparam int unsigned ND = 4;
  localparam int unsigned NM = 6;
  localparam int unsigned AW = 8;
  localparam int unsigned NREG = 1 + ND + NM;
  localparam logic [9:0] IMPL = 10'h1FF; // bit 9 unimplemented in hw model

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic rsp_valid, err;
  logic [31:0] rdata;
  logic [ND*10-1:0] ded_store;
  logic [NM*10-1:0] mux_store;
  logic [9:0] attr_wd;
  logic [ND-1:0] ded_qe;
  logic [NM-1:0] mux_qe;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pad_attr_bank #(.NumDed(ND), .NumMux(NM), .AddrW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rsp_valid_o(rsp_valid), .rdata_o(rdata), .err_o(err),
    .ded_attr_i(ded_store), .mux_attr_i(mux_store), .attr_wdata_o(attr_wd),
    .ded_qe_o(ded_qe), .mux_qe_o(mux_qe)
  );

  // hardware side model
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ded_store <= '0;
      mux_store <= '0;
    end else begin
      for (int k = 0; k < int'(ND); k++)
        if (ded_qe[k]) ded_store[k*10 +: 10] <= attr_wd & IMPL;
      for (int k = 0; k < int'(NM); k++)
        if (mux_qe[k]) mux_store[k*10 +: 10] <= attr_wd & IMPL;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  logic [31:0] r_data;
  logic r_err, r_vld;
  logic [ND+NM-1:0] r_qe;
  logic [9:0] r_wd;

  task automatic access(input logic w, input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    r_vld = rsp_valid; r_data = rdata; r_err = err; r_qe = {mux_qe, ded_qe}; r_wd = attr_wd;
    req = 1'b0; we = 1'b0;
    @(negedge clk);
    chk("R4/R5 pulse one cycle", 32'({mux_qe, ded_qe}), 32'd0);
  endtask

  function automatic logic [9:0] pat(input int i, input int s);
    return 10'((i * 97 + s * 331 + 10'h2A5) ^ (s << 9));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid reset", 32'(rsp_valid), 0);
    chk("R1 qe reset", 32'({mux_qe, ded_qe}), 0);
    rst_n = 1'b1;
    access(1'b0, 8'h00, 0);
    chk("R1 enable reads 1", r_data, 32'd1);
    chk("R2 rsp valid", 32'(r_vld), 1);

    for (int s = 0; s < 2; s++) begin
      for (int i = 1; i < int'(NREG); i++) begin
        logic [9:0] v;
        v = pat(i, s);
        access(1'b1, AW'(4 * i), {22'h3FFFFF, v});
        chk("R5 single qe", 32'(r_qe), 32'(1) << (i - 1));
        chk("R5 attr wdata", 32'(r_wd), 32'(v));
        chk("R2 write rdata zero", r_data, 0);
        chk("R6 no err", 32'(r_err), 0);
        access(1'b0, AW'(4 * i), 0);
        chk("R7 WARL readback", r_data, 32'(v & IMPL));
      end
    end

    for (int i = int'(NREG); i < (1 << (AW - 2)); i++) begin
      access(1'b1, AW'(4 * i), 32'h0);
      chk("R9 unmapped write err", 32'(r_err), 1);
      chk("R9 no qe", 32'(r_qe), 0);
      access(1'b0, AW'(4 * i), 0);
      chk("R9 unmapped rdata", r_data, 0);
    end
    access(1'b1, 8'h01, 32'h0);
    chk("R9 misaligned err", 32'(r_err), 1);
    chk("R9 misaligned no qe", 32'(r_qe), 0);
    access(1'b0, 8'h00, 0);
    chk("R9 lock unchanged", r_data, 32'd1);

    access(1'b1, 8'h00, 32'hFFFF_FFFF);
    access(1'b0, 8'h00, 0);
    chk("R3 write 1 keeps", r_data, 32'd1);
    access(1'b1, 8'h00, 32'hFFFF_FFFE);
    access(1'b0, 8'h00, 0);
    chk("R3 cleared", r_data, 32'd0);
    chk("R8 upper zero", r_data & 32'hFFFF_FFFE, 0);
    for (int n = 0; n < 4; n++) begin
      access(1'b1, 8'h00, 32'h1);
      access(1'b0, 8'h00, 0);
      chk("R3 sticky", r_data, 32'd0);
    end

    for (int i = 1; i < int'(NREG); i++) begin
      access(1'b1, AW'(4 * i), 32'h3FF);
      chk("R4 no qe locked", 32'(r_qe), 0);
      access(1'b0, AW'(4 * i), 0);
      chk("R4 value kept", r_data, 32'(pat(i, 1) & IMPL));
    end

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    access(1'b0, 8'h00, 0);
    chk("R1 enable back after reset", r_data, 32'd1);
    access(1'b1, 8'h04, 32'h155);
    chk("R5 writes after reset", 32'(r_qe), 32'd1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule